// File: doc/BRIEF.md
# Receive descriptor DMA engine

This block moves received frame bytes into host memory. It follows a list of descriptors in host memory. Each descriptor is four 32-bit words placed at increasing addresses. Word 0 holds status and the ownership flag. Word 1 holds control and the buffer size. Word 2 is the buffer address. Word 3 is the link to the next descriptor. Frames arrive as a byte stream with a final-byte marker. The engine writes each byte into the buffer of the descriptor it owns. It then writes back a status word and clears the ownership flag, which hands the descriptor back to the host.

When the engine fetches a descriptor that the host still owns, it raises a sticky buffer-unavailable flag and suspends. While suspended it accepts incoming bytes and throws them away, and it counts each frame lost this way. A poll-demand pulse makes it fetch the same descriptor again. A run control enables the engine, and every new start begins at a list base address.

Top module: `rx_desc_dma`

## Requirements
- R1: After reset, rbu_o is 0, miss_cnt_o is 0, rx_ready_o is 0 and mem_req_o is 0 until run_i is set.
- R2: When run_i rises from idle, the engine reads the descriptor at list_base_i. It reads the four words at offsets 0, 4, 8 and 12, and rx_ready_o stays low while it fetches.
- R3: Frame byte k of a descriptor's buffer is written at buffer address + k, in byte lane k mod 4 of a little-endian word. A partial final word enables only lanes 0 up to the last byte written, so bytes past the frame are left unchanged.
- R4: For a frame that ends in a descriptor, the status write-back has bit 31 = 0, bits 29:16 = total byte count of the frame as delivered (CRC included), bit 9 = first flag and bit 8 = last flag. A frame that fits in one buffer sets both flags.
- R5: The buffer size is control bits 12:0. A frame longer than the buffer continues in the next descriptor. A non-final descriptor gets status with length 0 and bit 8 = 0. Bit 9 is set only in the descriptor that holds the frame's first byte.
- R6: If control bit 14 is 1, the next descriptor address is word 3. If it is 0, the next descriptor address is the current descriptor address + 16.
- R7: A fetched status word with bit 31 = 0 sets rbu_o and suspends the engine. rbu_o stays 1 until a rbu_clr_i pulse clears it on the next edge. Nothing is written while the engine is suspended.
- R8: A poll_i pulse while suspended makes the engine read the same descriptor's status word in the next cycle.
- R9: While suspended, rx_ready_o is 1 and bytes are dropped. miss_cnt_o increments once at the final byte of each dropped frame. If suspension happens mid-frame, the rest of that frame is dropped.
- R10: Clearing run_i while suspended drops rx_ready_o to 0. Setting run_i again restarts at list_base_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Engine enable |
| poll_i | input | 1 | Poll-demand pulse |
| rbu_clr_i | input | 1 | Clears the buffer-unavailable flag |
| list_base_i | input | AW | Address of the first descriptor |
| rx_valid_i | input | 1 | Frame byte valid |
| rx_data_i | input | 8 | Frame byte |
| rx_last_i | input | 1 | Final byte of frame |
| rx_ready_o | output | 1 | Byte accepted when high with valid |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write (else read) |
| mem_addr_o | output | AW | Byte address |
| mem_be_o | output | 4 | Byte lane enables for writes |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, one cycle after a read request |
| rbu_o | output | 1 | Sticky buffer-unavailable flag |
| miss_cnt_o | output | MISS_W | Dropped frame count |

## Verification
Read data comes back one cycle after the request. The ownership decision and the rise of rbu_o therefore land on the second edge after the status read is issued. Each buffer word is written on the same edge that accepts its last byte, and the status write-back follows one cycle after the final byte. rbu_o clears and the poll-driven status read appears one edge after the pulse, and the bench samples these at the falling edge that follows. Memory contents are checked only after a settle window of several cycles that covers the write-back and the next descriptor fetch.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int OWN_BIT   = 31;
  localparam int LEN_LSB   = 16;
  localparam int LEN_W     = 14;
  localparam int FIRST_BIT = 9;
  localparam int LAST_BIT  = 8;
  localparam int CHAIN_BIT = 14;
  localparam int SIZE_W    = 13;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_OWN, S_CHK, S_RD1, S_RD2, S_RD3, S_DATA, S_WSTAT, S_SUSP
  } rxd_state_e;
endpackage

// File: rtl/rxd_packer.sv
module rxd_packer (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        acc_i,
  input  logic [7:0]  byte_i,
  input  logic [1:0]  lane_i,
  input  logic        flush_i,
  output logic        we_o,
  output logic [31:0] wdata_o,
  output logic [3:0]  be_o
);
  logic [3:0][7:0] hold_q;
  logic [3:0][7:0] merged;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= '0;
    else if (acc_i) hold_q[lane_i] <= byte_i;
  end

  always_comb begin
    merged         = hold_q;
    merged[lane_i] = byte_i;
  end

  assign wdata_o = merged;
  assign we_o    = acc_i && (lane_i == 2'd3 || flush_i);

  for (genvar i = 0; i < 4; i++) begin : g_be
    assign be_o[i] = (2'(i) <= lane_i);
  end

  AST_BE_CONTIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> (be_o == 4'h1 || be_o == 4'h3 || be_o == 4'h7 || be_o == 4'hF)); // R3
endmodule

// File: rtl/rxd_miss_cnt.sv
module rxd_miss_cnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + W'(1);
  end

  AST_MISS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(cnt_o)); // R9
endmodule

// File: rtl/rx_desc_dma.sv
module rx_desc_dma
  import rxd_pkg::*;
#(
  parameter int AW     = 32,
  parameter int MISS_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              poll_i,
  input  logic              rbu_clr_i,
  input  logic [AW-1:0]     list_base_i,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_last_i,
  output logic              rx_ready_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [3:0]        mem_be_o,
  output logic [31:0]       mem_wdata_o,
  input  logic [31:0]       mem_rdata_i,
  output logic              rbu_o,
  output logic [MISS_W-1:0] miss_cnt_o
);
  localparam logic [AW-1:0] W1 = AW'(4);
  localparam logic [AW-1:0] W2 = AW'(8);
  localparam logic [AW-1:0] W3 = AW'(12);
  localparam logic [AW-1:0] DESC_STRIDE = AW'(16);

  rxd_state_e state_q;
  logic [AW-1:0]     cur_q, nxt_q, buf_q;
  logic [SIZE_W-1:0] bsize_q, bcnt_q;
  logic [LEN_W-1:0]  total_q;
  logic              chain_q, first_q, last_q, skip_q;

  logic acc, store, drop_end, full, flush;
  logic pk_we;
  logic [31:0] pk_wdata;
  logic [3:0]  pk_be;
  logic [AW-1:0] word_addr;
  logic [31:0] stat_word;

  assign rx_ready_o = (state_q == S_DATA) || (state_q == S_SUSP);
  assign acc        = rx_valid_i && rx_ready_o;
  assign store      = acc && (state_q == S_DATA) && !skip_q;
  assign drop_end   = acc && rx_last_i && ((state_q == S_SUSP) || skip_q);
  assign full       = ({1'b0, bcnt_q} + (SIZE_W+1)'(1)) == {1'b0, bsize_q};
  assign flush      = rx_last_i || full;
  assign word_addr  = buf_q + {{(AW-SIZE_W){1'b0}}, bcnt_q[SIZE_W-1:2], 2'b00};
  assign stat_word  = {2'b00, (last_q ? total_q : {LEN_W{1'b0}}), 6'd0,
                       first_q, last_q, 8'd0};

  rxd_packer u_pack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .acc_i   (store),
    .byte_i  (rx_data_i),
    .lane_i  (bcnt_q[1:0]),
    .flush_i (flush),
    .we_o    (pk_we),
    .wdata_o (pk_wdata),
    .be_o    (pk_be)
  );

  rxd_miss_cnt #(.W(MISS_W)) u_miss (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (drop_end),
    .cnt_o  (miss_cnt_o)
  );

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = cur_q;
    mem_be_o    = 4'h0;
    mem_wdata_o = 32'd0;
    unique case (state_q)
      S_RD_OWN: mem_req_o = 1'b1;
      S_CHK: begin
        mem_req_o  = mem_rdata_i[OWN_BIT];
        mem_addr_o = cur_q + W1;
      end
      S_RD1: begin
        mem_req_o  = 1'b1;
        mem_addr_o = cur_q + W2;
      end
      S_RD2: begin
        mem_req_o  = 1'b1;
        mem_addr_o = cur_q + W3;
      end
      S_DATA: begin
        mem_req_o   = pk_we && !skip_q;
        mem_we_o    = 1'b1;
        mem_addr_o  = word_addr;
        mem_be_o    = pk_be;
        mem_wdata_o = pk_wdata;
      end
      S_WSTAT: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_be_o    = 4'hF;
        mem_wdata_o = stat_word;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cur_q   <= '0;
      nxt_q   <= '0;
      buf_q   <= '0;
      bsize_q <= '0;
      bcnt_q  <= '0;
      total_q <= '0;
      chain_q <= 1'b0;
      first_q <= 1'b1;
      last_q  <= 1'b0;
      skip_q  <= 1'b0;
      rbu_o   <= 1'b0;
    end else begin
      if (state_q == S_CHK && !mem_rdata_i[OWN_BIT]) rbu_o <= 1'b1;
      else if (rbu_clr_i) rbu_o <= 1'b0;

      unique case (state_q)
        S_IDLE: if (run_i) begin
          cur_q   <= list_base_i;
          first_q <= 1'b1;
          skip_q  <= 1'b0;
          total_q <= '0;
          state_q <= S_RD_OWN;
        end
        S_RD_OWN: state_q <= run_i ? S_CHK : S_IDLE;
        S_CHK: begin
          if (mem_rdata_i[OWN_BIT]) state_q <= S_RD1;
          else begin
            state_q <= S_SUSP;
            if (!first_q) skip_q <= 1'b1;  // frame cut short: drop its tail
            first_q <= 1'b1;
            total_q <= '0;
          end
        end
        S_RD1: begin
          bsize_q <= mem_rdata_i[SIZE_W-1:0];
          chain_q <= mem_rdata_i[CHAIN_BIT];
          state_q <= S_RD2;
        end
        S_RD2: begin
          buf_q   <= mem_rdata_i[AW-1:0];
          state_q <= S_RD3;
        end
        S_RD3: begin
          nxt_q   <= mem_rdata_i[AW-1:0];
          bcnt_q  <= '0;
          state_q <= S_DATA;
        end
        S_DATA: if (acc) begin
          if (skip_q) begin
            if (rx_last_i) skip_q <= 1'b0;
          end else begin
            bcnt_q  <= bcnt_q + SIZE_W'(1);
            total_q <= total_q + LEN_W'(1);
            if (flush) begin
              last_q  <= rx_last_i;
              state_q <= S_WSTAT;
            end
          end
        end
        S_WSTAT: begin
          first_q <= last_q;
          if (last_q) total_q <= '0;
          cur_q   <= chain_q ? nxt_q : cur_q + DESC_STRIDE;
          state_q <= S_RD_OWN;
        end
        S_SUSP: begin
          if (acc) skip_q <= !rx_last_i;
          if (!run_i) state_q <= S_IDLE;
          else if (poll_i) state_q <= S_RD_OWN;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  AST_RBU_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rbu_o && !rbu_clr_i |=> rbu_o); // R7
  AST_SUSP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_SUSP |-> !mem_req_o); // R7
  AST_POLL_REFETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_SUSP && run_i && poll_i |=>
      mem_req_o && !mem_we_o && mem_addr_o == $past(cur_q)); // R8
  AST_STAT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_WSTAT |-> mem_we_o && !mem_wdata_o[OWN_BIT]); // R4
  AST_FETCH_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_we_o |-> !rx_ready_o); // R2
endmodule

// File: tb/sim_rx_desc_dma.sv
`timescale 1ns/1ps
module sim_rx_desc_dma;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0, poll = 1'b0, rbu_clr = 1'b0;
  logic [31:0] list_base = 32'h0;
  logic rx_valid = 1'b0, rx_last = 1'b0;
  logic [7:0] rx_data = 8'h0;
  logic rx_ready, mem_req, mem_we, rbu;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = 32'h0;
  logic [3:0] mem_be;
  logic [15:0] miss;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] mem [0:1023];

  always #2.5 clk = ~clk;

  rx_desc_dma u0 (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .poll_i(poll), .rbu_clr_i(rbu_clr),
    .list_base_i(list_base), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .rx_last_i(rx_last), .rx_ready_o(rx_ready), .mem_req_o(mem_req),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_be_o(mem_be),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .rbu_o(rbu),
    .miss_cnt_o(miss)
  );

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        for (int i = 0; i < 4; i++)
          if (mem_be[i]) mem[mem_addr[11:2]][8*i +: 8] <= mem_wdata[8*i +: 8];
      end else mem_rdata <= mem[mem_addr[11:2]];
    end
  end

  function automatic logic [7:0] pat(int id, int k);
    return 8'(id * 37 + k * 5 + 1);
  endfunction

  function automatic logic [7:0] mbyte(int a);
    return mem[a >> 2][8 * (a % 4) +: 8];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_bytes(string req, int id, int k0, int n, int addr);
    int bad = -1;
    for (int k = 0; k < n; k++)
      if (bad < 0 && mbyte(addr + k) !== pat(id, k0 + k)) bad = k;
    n_tests++;
    if (bad >= 0) begin
      n_fail++;
      $display("FAIL %s: byte %0d actual %h expected %h", req, k0 + bad,
               mbyte(addr + bad), pat(id, k0 + bad));
    end
  endtask

  task automatic send_frame(int id, int n);
    for (int k = 0; k < n; k++) begin
      rx_valid = 1'b1;
      rx_data  = pat(id, k);
      rx_last  = (k == n - 1);
      while (!rx_ready) @(negedge clk);
      @(negedge clk);
    end
    rx_valid = 1'b0;
    rx_last  = 1'b0;
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clr();
    rbu_clr = 1'b1; @(negedge clk); rbu_clr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 rbu", {31'd0, rbu}, 0);
    check("R1 miss", {16'd0, miss}, 0);
    check("R1 ready/req", {30'd0, rx_ready, mem_req}, 0);
  endtask

  task automatic t_single();
    list_base = 32'h0; run = 1'b1;
    settle(10);
    send_frame(1, 10);
    settle(10);
    check("R4 single status", mem[0], 32'h000A_0300);
    check_bytes("R2/R3 single bytes", 1, 0, 10, 32'h100);
    check("R3 lanes past frame", {24'd0, mbyte(32'h10A)}, 32'hEE);
  endtask

  task automatic t_span();
    send_frame(2, 100);
    settle(12);
    check("R5 first part status", mem[32'h10 >> 2], 32'h0000_0200);
    check("R5 R6 tail status (chained hop)", mem[32'h40 >> 2], 32'h0064_0100);
    check_bytes("R5 first part bytes", 2, 0, 64, 32'h200);
    check_bytes("R5 tail bytes", 2, 64, 36, 32'h300);
    check("R6 decoy untouched", mem[32'h20 >> 2], 32'h8000_0000);
    check("R7 rbu on host-owned", {31'd0, rbu}, 1);
  endtask

  task automatic t_suspend_drop();
    settle(20);
    check("R7 rbu sticky", {31'd0, rbu}, 1);
    send_frame(3, 5);
    settle(3);
    check("R9 miss count", {16'd0, miss}, 1);
    check("R7 no write while suspended", {24'd0, mbyte(32'h380)}, 32'hEE);
    check("R9 ready while suspended", {31'd0, rx_ready}, 1);
    pulse_clr();
    check("R7 rbu clear", {31'd0, rbu}, 0);
  endtask

  task automatic t_poll();
    mem[32'h50 >> 2] = 32'h8000_0000;
    poll = 1'b1; @(negedge clk); poll = 1'b0;
    check("R8 refetch same descriptor", {mem_req, mem_we, mem_addr[29:0]},
          {2'b10, 30'h50});
    settle(6);
    send_frame(4, 8);
    settle(12);
    check("R6 sequential next status", mem[32'h50 >> 2], 32'h0008_0300);
    check_bytes("R6 sequential next bytes", 4, 0, 8, 32'h380);
    check("R7 rbu on returned desc", {31'd0, rbu}, 1);
  endtask

  task automatic t_midframe();
    pulse_clr();
    mem[0] = 32'h8000_0000;
    poll = 1'b1; @(negedge clk); poll = 1'b0;
    settle(6);
    send_frame(5, 70);
    settle(6);
    check("R5 partial status", mem[0], 32'h0000_0200);
    check_bytes("R5 partial bytes", 5, 0, 64, 32'h100);
    check("R9 mid-frame drop count", {16'd0, miss}, 2);
    check("R9 tail not stored", {24'd0, mbyte(32'h200)}, {24'd0, pat(2, 0)});
    check("R7 rbu mid-frame", {31'd0, rbu}, 1);
  endtask

  task automatic t_restart();
    run = 1'b0; @(negedge clk);
    check("R10 stopped ready", {31'd0, rx_ready}, 0);
    mem[32'h10 >> 2] = 32'h8000_0000;
    list_base = 32'h10;
    settle(2);
    run = 1'b1;
    settle(8);
    send_frame(6, 4);
    settle(10);
    check("R10 restart status", mem[32'h10 >> 2], 32'h0004_0300);
    check_bytes("R10 restart bytes", 6, 0, 4, 32'h200);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'hEEEE_EEEE;
    mem[32'h00 >> 2] = 32'h8000_0000; mem[32'h04 >> 2] = 32'h0000_4040;
    mem[32'h08 >> 2] = 32'h100;       mem[32'h0C >> 2] = 32'h010;
    mem[32'h10 >> 2] = 32'h8000_0000; mem[32'h14 >> 2] = 32'h0000_4040;
    mem[32'h18 >> 2] = 32'h200;       mem[32'h1C >> 2] = 32'h040;
    mem[32'h20 >> 2] = 32'h8000_0000; mem[32'h24 >> 2] = 32'h0000_4040;
    mem[32'h28 >> 2] = 32'h3C0;       mem[32'h2C >> 2] = 32'h000;
    mem[32'h40 >> 2] = 32'h8000_0000; mem[32'h44 >> 2] = 32'h0000_0040;
    mem[32'h48 >> 2] = 32'h300;       mem[32'h4C >> 2] = 32'hFFC;
    mem[32'h50 >> 2] = 32'h0000_0000; mem[32'h54 >> 2] = 32'h0000_4040;
    mem[32'h58 >> 2] = 32'h380;       mem[32'h5C >> 2] = 32'h000;
    settle(3);
    rst_n = 1'b1;
    settle(2);
    t_reset();
    t_single();
    t_span();
    t_suspend_drop();
    t_poll();
    t_midframe();
    t_restart();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule